// File: doc/BRIEF.md
# DMA Request Dispatcher

This block sits between the request sources of a chip (an external device request line, two serial ports, a timer capture event) and a four-channel DMA engine. Each channel reports three things: whether it is enabled, whether its transfer has ended, and a 4-bit code that says which request source it is waiting on. When a request pulse arrives, the dispatcher sends a one-cycle start strobe to every channel that is eligible and whose code matches that source. Each strobe asks the channel for one unit transfer. If several channels listen to the same source, one pulse starts all of them in the same cycle. Arbitration for the shared bus is done later, in the engine.

Channels with an auto-request code need no trigger. They get a start in every cycle for as long as they stay eligible. A global operation field gates everything. When that field holds any value other than its single "run" encoding, no channel is started.

Top module: `dma_req_dispatch`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, start_o is all zeros.
- R2: A start is issued only when op_ctrl_i equals 3'b001. Every other value of op_ctrl_i suppresses all starts, including auto-request starts.
- R3: Channel i is eligible only when ch_en_i[i] is 1 and ch_end_i[i] is 0. An ineligible channel never receives a start.
- R4: Channel i's code is ch_code_i[4*i+3:4*i]. Codes 4'h0, 4'h2 and 4'h3 are started by ext_req_i.
- R5: Codes 4'h4, 4'h5 and 4'h6 are auto-request codes. An eligible channel holding one of them gets start_o[i]=1 in every cycle after a cycle in which it was eligible, with no request input needed.
- R6: Code 4'h8 is started by ser0_tx_i, code 4'h9 by ser0_rx_i, code 4'hA by ser1_tx_i and code 4'hB by ser1_rx_i.
- R7: Codes 4'hC, 4'hD and 4'hE are all started by tmr_cap_i.
- R8: Codes 4'h1, 4'h7 and 4'hF never produce a start, whatever the inputs.
- R9: A single request pulse starts every eligible channel whose code matches it, in the same cycle.
- R10: start_o[i] rises in the cycle after the matching request is sampled. A one-cycle request produces a one-cycle start, and no start appears without a matching request or an auto-request code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_ctrl_i | input | 3 | Global operation field; 3'b001 means run |
| ch_en_i | input | 4 | Per-channel enable |
| ch_end_i | input | 4 | Per-channel transfer-end flag |
| ch_code_i | input | 16 | Per-channel request-source codes, 4 bits each, channel 0 in the low nibble |
| ext_req_i | input | 1 | External device request pulse |
| ser0_tx_i | input | 1 | Serial port 0 transmit-empty request |
| ser0_rx_i | input | 1 | Serial port 0 receive-full request |
| ser1_tx_i | input | 1 | Serial port 1 transmit-empty request |
| ser1_rx_i | input | 1 | Serial port 1 receive-full request |
| tmr_cap_i | input | 1 | Timer input-capture request |
| start_o | output | 4 | Per-channel one-unit start strobe |

## Verification
On every cycle the assertions check a set of rules. The run gate must suppress starts, and an ineligible channel must get no strobe. A reserved code must stay silent, and an eligible auto-request channel must keep receiving starts. A start must not appear when no matching request arrived, and a timer pulse must reach every timer-coded channel together. Only the bench's scenarios show that each request source maps to exactly the right codes. The bench sweeps all sixteen codes against every source and also checks the one-cycle pulse width and the reset value.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  localparam int CODE_W = 4;

  typedef struct packed {
    logic ext;
    logic s0_tx;
    logic s0_rx;
    logic s1_tx;
    logic s1_rx;
    logic tmr;
  } req_t;

  function automatic logic is_auto(logic [CODE_W-1:0] code);
    return (code == 4'h4) || (code == 4'h5) || (code == 4'h6);
  endfunction

  // Fixed source table; unlisted codes are reserved and never fire.
  function automatic logic code_hit(logic [CODE_W-1:0] code, req_t r);
    logic hit;
    case (code)
      4'h0, 4'h2, 4'h3: hit = r.ext;
      4'h4, 4'h5, 4'h6: hit = 1'b1;
      4'h8:             hit = r.s0_tx;
      4'h9:             hit = r.s0_rx;
      4'hA:             hit = r.s1_tx;
      4'hB:             hit = r.s1_rx;
      4'hC, 4'hD, 4'hE: hit = r.tmr;
      default:          hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dmr_gate.sv
module dmr_gate
  import dmr_pkg::*;
#(
  parameter int OPER_W = 3
) (
  input  logic [OPER_W-1:0] op_ctrl_i,
  input  logic              ext_req_i,
  input  logic              ser0_tx_i,
  input  logic              ser0_rx_i,
  input  logic              ser1_tx_i,
  input  logic              ser1_rx_i,
  input  logic              tmr_cap_i,
  output logic              go_o,
  output req_t              req_o
);

  localparam logic [OPER_W-1:0] OPER_RUN = OPER_W'(1);

  always_comb begin
    go_o        = (op_ctrl_i == OPER_RUN);
    req_o.ext   = ext_req_i;
    req_o.s0_tx = ser0_tx_i;
    req_o.s0_rx = ser0_rx_i;
    req_o.s1_tx = ser1_tx_i;
    req_o.s1_rx = ser1_rx_i;
    req_o.tmr   = tmr_cap_i;
  end

endmodule

// File: rtl/dmr_slot.sv
module dmr_slot
  import dmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              en_i,
  input  logic              end_i,
  input  logic [CODE_W-1:0] code_i,
  input  req_t              req_i,
  output logic              start_o
);

  logic elig;
  logic start_q;

  assign elig = go_i & en_i & ~end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= elig & code_hit(code_i, req_i);
  end

  assign start_o = start_q;

  AST_INELIG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || end_i) |=> !start_o); // R3

  AST_AUTO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && en_i && !end_i && code_i >= 4'h4 && code_i <= 4'h6) |=> start_o); // R5

  AST_RESERVED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 4'h1 || code_i == 4'h7 || code_i == 4'hF) |=> !start_o); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && !is_auto(code_i)) |=> !start_o); // R10

endmodule

// File: rtl/dma_req_dispatch.sv
module dma_req_dispatch
  import dmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OPER_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [OPER_W-1:0]        op_ctrl_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0]        ch_end_i,
  input  logic [NUM_CH*CODE_W-1:0] ch_code_i,
  input  logic                     ext_req_i,
  input  logic                     ser0_tx_i,
  input  logic                     ser0_rx_i,
  input  logic                     ser1_tx_i,
  input  logic                     ser1_rx_i,
  input  logic                     tmr_cap_i,
  output logic [NUM_CH-1:0]        start_o
);

  localparam logic [OPER_W-1:0] OPER_RUN = OPER_W'(1);

  logic go;
  req_t req;

  dmr_gate #(.OPER_W(OPER_W)) u_gate (
    .op_ctrl_i (op_ctrl_i),
    .ext_req_i (ext_req_i),
    .ser0_tx_i (ser0_tx_i),
    .ser0_rx_i (ser0_rx_i),
    .ser1_tx_i (ser1_tx_i),
    .ser1_rx_i (ser1_rx_i),
    .tmr_cap_i (tmr_cap_i),
    .go_o      (go),
    .req_o     (req)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmr_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (go),
      .en_i    (ch_en_i[g]),
      .end_i   (ch_end_i[g]),
      .code_i  (ch_code_i[g*CODE_W +: CODE_W]),
      .req_i   (req),
      .start_o (start_o[g])
    );
  end

  // All channels eligible and timer-coded: used only by the fan-out check.
  logic [NUM_CH-1:0] tmr_ready;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      tmr_ready[i] = ch_en_i[i] && !ch_end_i[i] &&
                     (ch_code_i[i*CODE_W +: CODE_W] >= 4'hC) &&
                     (ch_code_i[i*CODE_W +: CODE_W] <= 4'hE);
    end
  end

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_ctrl_i != OPER_RUN) |=> (start_o == '0)); // R2

  AST_TMR_FANOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_ctrl_i == OPER_RUN && tmr_cap_i && (&tmr_ready)) |=> (&start_o)); // R9

endmodule

// File: tb/tb_dma_req_dispatch.sv
module tb_dma_req_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'b001;
  logic [3:0]  en = '0;
  logic [3:0]  endb = '0;
  logic [15:0] codes = '0;
  logic [5:0]  req = '0; // {ext, s0tx, s0rx, s1tx, s1rx, tmr}
  logic [3:0]  start;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_dispatch dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_ctrl_i (op),
    .ch_en_i   (en),
    .ch_end_i  (endb),
    .ch_code_i (codes),
    .ext_req_i (req[5]),
    .ser0_tx_i (req[4]),
    .ser0_rx_i (req[3]),
    .ser1_tx_i (req[2]),
    .ser1_rx_i (req[1]),
    .tmr_cap_i (req[0]),
    .start_o   (start)
  );

  function automatic logic [3:0] model(logic [2:0] o, logic [3:0] e, logic [3:0] d,
                                       logic [15:0] c, logic [5:0] r);
    logic [3:0] res;
    for (int i = 0; i < NCH; i++) begin
      logic [3:0] k;
      logic h;
      k = c[4*i +: 4];
      case (k)
        4'h0, 4'h2, 4'h3: h = r[5];
        4'h4, 4'h5, 4'h6: h = 1'b1;
        4'h8: h = r[4];
        4'h9: h = r[3];
        4'hA: h = r[2];
        4'hB: h = r[1];
        4'hC, 4'hD, 4'hE: h = r[0];
        default: h = 1'b0;
      endcase
      res[i] = (o == 3'b001) && e[i] && !d[i] && h;
    end
    return res;
  endfunction

  function automatic string code_tag(logic [3:0] k);
    if (k == 4'h0 || k == 4'h2 || k == 4'h3) return "R4";
    if (k >= 4'h4 && k <= 4'h6) return "R5";
    if (k >= 4'h8 && k <= 4'hB) return "R6";
    if (k >= 4'hC && k <= 4'hE) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: start_o act=%b exp=%b", tag, act, exp);
    end
  endtask

  // Pulse r for one cycle; check the strobe cycle and the cycle after (R10).
  task automatic pulse_chk(string tag, logic [5:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
    chk(tag, start, model(op, en, endb, codes, r));
    req = '0;
    @(negedge clk);
    chk({tag, "/R10"}, start, model(op, en, endb, codes, '0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in reset", start, 4'b0000);
    en = 4'hF; codes = 16'h4444;
    @(negedge clk);
    chk("R1 in reset auto", start, 4'b0000);
    rst_n = 1'b1;
    chk("R1 first cycle", start, 4'b0000);
    @(negedge clk);
    chk("R1 after release", start, 4'b1111);
    en = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_code_sweep();
    op = 3'b001; endb = '0; en = 4'b0001;
    for (int k = 0; k < 16; k++) begin
      codes = {12'h111, 4'(k)};
      for (int s = 0; s < 7; s++) begin
        logic [5:0] r;
        r = (s < 6) ? (6'b1 << s) : 6'b0;
        pulse_chk(code_tag(4'(k)), r);
      end
    end
    en = '0;
    @(negedge clk);
  endtask

  task automatic t_gate();
    en = 4'b0011; endb = '0; codes = 16'h0050;
    for (int o = 0; o < 8; o++) begin
      op = 3'(o);
      pulse_chk("R2", 6'b100000);
    end
    op = 3'b001;
    en = '0;
    @(negedge clk);
  endtask

  task automatic t_elig();
    codes = 16'hC000; // ch3 timer, others ext
    en = 4'b1011; endb = 4'b0001;
    pulse_chk("R3 ext", 6'b100000);
    pulse_chk("R3 tmr", 6'b000001);
    endb = 4'b1000;
    pulse_chk("R3 end", 6'b000001);
    en = '0; endb = '0;
    @(negedge clk);
  endtask

  task automatic t_fanout();
    en = 4'hF; endb = '0;
    codes = 16'h0EDC;
    pulse_chk("R9 tmr", 6'b000001);
    pulse_chk("R9 ext", 6'b100000);
    codes = 16'hAA9A;
    pulse_chk("R9 s1tx", 6'b000100);
    pulse_chk("R9 both", 6'b001100);
    codes = 16'hEDCE;
    pulse_chk("R9 all tmr", 6'b000001);
    en = '0;
    @(negedge clk);
  endtask

  task automatic t_auto();
    codes = 16'h1654; en = 4'b0111; endb = '0;
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R5 continuous", start, 4'b0111);
    end
    en = 4'b0101;
    @(negedge clk);
    chk("R5 drop enable", start, 4'b0101);
    op = 3'b000;
    @(negedge clk);
    chk("R5 gate off", start, 4'b0000);
    op = 3'b001; en = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_timing();
    codes = 16'h0009; en = 4'b0001; endb = '0;
    @(negedge clk);
    req = 6'b001000;
    #1;
    chk("R10 not combinational", start, 4'b0000);
    @(negedge clk);
    chk("R10 next cycle", start, 4'b0001);
    req = '0;
    @(negedge clk);
    chk("R10 one wide", start, 4'b0000);
    en = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_code_sweep();
    t_gate();
    t_elig();
    t_fanout();
    t_auto();
    t_timing();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule